// File: doc/BRIEF.md
# Zero-Turnaround Flow-Through Synchronous SRAM

This block is a single-port synchronous memory that accepts a new command on every enabled clock and never needs an idle cycle when the traffic switches between reads and writes. A read is flow-through: the array is read at the edge that registers the address, and the word is presented during the cycle that follows. A write registers its address one edge ahead of its data. The data and the byte-lane selects are sampled at the next enabled edge, so the write data phase and a read data phase never compete for the bus.

The pending write address is held for one stage. A read that targets that address at the same edge gets the newly written byte lanes merged into the array word. A two-bit burst counter lets the host issue a start address once and then advance through four words in linear or interleaved order. Three chip selects, a clock enable and a sleep input gate the command stream. An asynchronous output enable gates the drive of the read bus, and the drive is forced off in every write data phase. The bidirectional data bus is split into a write-data input, a read-data output and a drive-enable output.

Top module: `zt_sram`

## Requirements
- R1: While `rst` is high at a clock edge, all command, burst and phase state clears. After that edge `rdata_drive` is low until a read is issued.
- R2: A read issued at an enabled edge k puts the word stored at its address on `rdata` after edge k, and holds it there until the next enabled edge.
- R3: A write issued at enabled edge k takes `wdata` and `byte_wr` at the next enabled edge and stores them at the address registered at edge k.
- R4: Byte lane i is bits [9i+8:9i] of the 36-bit word. A write changes lane i only when `byte_wr[i]` is 1 in its data phase.
- R5: Reads and writes can follow each other in any order on consecutive enabled edges. No command is lost or delayed.
- R6: A read issued at the same edge that commits a write to the same address returns the new lanes for the bytes that the write selected and the old lanes for the others.
- R7: A new command needs `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0. Any other combination is a deselect: nothing is read or written and `rdata_drive` is low in the following cycle.
- R8: While `clk_en` is low, no register changes. `rdata` holds, and a pending write waits for the next enabled edge to take its data.
- R9: `rdata_drive` follows `out_en` combinationally during a read data phase, with no clock edge needed.
- R10: In the cycle after a write is issued, `rdata_drive` is low whatever the value of `out_en`.
- R11: With `burst_adv`=1 the previous command type continues. When `order_ilv`=0, the two low address bits of beat n are (start + n) mod 4 and the upper bits stay those of the start address.
- R12: When `order_ilv`=1, the two low address bits of beat n are start XOR n.
- R13: `sleep`=1 at an edge makes that edge idle, and a burst advance that follows it also stays idle. The data phase of a write issued before the sleep still commits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| clk_en | input | 1 | Clock qualifier; low stalls every register |
| addr | input | ADDR_W | Word address for a new command |
| wr_en | input | 1 | 1 = write command, 0 = read command |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| burst_adv | input | 1 | 1 = advance the burst, 0 = load a new address |
| order_ilv | input | 1 | Burst order: 0 linear, 1 interleaved |
| sleep | input | 1 | Forces the command edge idle |
| out_en | input | 1 | Asynchronous read-bus drive enable, active high |
| byte_wr | input | LANES | Byte-lane write selects for the data phase |
| wdata | input | LANES*LANE_W | Write data for the data phase |
| rdata | output | LANES*LANE_W | Read data |
| rdata_drive | output | 1 | Drive enable for the read data onto the shared bus |

## Verification
The hardest case to reach is a read that hits the write whose data arrives at the same edge, especially with a partial byte mask. Here the array still returns its old word, and only the merge path gives the right answer. The stimulus issues a write followed at once by a read of the same address, with alternating masks. It also runs a long write/read alternation in which each read targets the write just before it. Stalls with `clk_en` low are inserted between a write command and its data phase, so the holding stage must keep its address while garbage sits on the data bus.

// File: rtl/zt_sram_pkg.sv
package zt_sram_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;
endpackage

// File: rtl/zt_cmd_seq.sv
// Command decode and burst address generation.
module zt_cmd_seq
  import zt_sram_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int BURST_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clk_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              sel_a_n,
  input  logic              sel_b,
  input  logic              sel_c_n,
  input  logic              burst_adv,
  input  logic              order_ilv,
  input  logic              sleep,
  output op_e               issue_op,
  output logic [ADDR_W-1:0] issue_addr
);
  logic [ADDR_W-1:0]  base_q;
  logic [BURST_W-1:0] cnt_q;
  logic [BURST_W-1:0] cnt_nxt;
  logic [BURST_W-1:0] burst_lo;
  op_e                last_q;
  logic               selected;

  assign selected = !sel_a_n && sel_b && !sel_c_n;
  assign cnt_nxt  = cnt_q + 1'b1;

  generate
    if (BURST_W > 0) begin : g_order
      always_comb begin
        if (order_ilv) burst_lo = base_q[BURST_W-1:0] ^ cnt_nxt;
        else           burst_lo = base_q[BURST_W-1:0] + cnt_nxt;
      end
    end
  endgenerate

  always_comb begin
    issue_op   = OP_IDLE;
    issue_addr = addr;
    if (rst || sleep) begin
      issue_op = OP_IDLE;
    end else if (burst_adv) begin
      issue_op   = last_q;
      issue_addr = {base_q[ADDR_W-1:BURST_W], burst_lo};
    end else if (selected) begin
      issue_op = wr_en ? OP_WRITE : OP_READ;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      last_q <= OP_IDLE;
      base_q <= '0;
      cnt_q  <= '0;
    end else if (clk_en) begin
      last_q <= issue_op;
      if (burst_adv) begin
        cnt_q <= cnt_nxt;
      end else begin
        base_q <= addr;
        cnt_q  <= '0;
      end
    end
  end
endmodule

// File: rtl/zt_sram_array.sv
// Byte-lane storage: one synchronous-read memory per lane.
module zt_sram_array #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rd_en,
  input  logic [ADDR_W-1:0]       rd_addr,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [LANES-1:0]        wr_be,
  input  logic [LANES*LANE_W-1:0] wr_data,
  output logic [LANES*LANE_W-1:0] rd_q
);
  localparam int DEPTH = 1 << ADDR_W;

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [LANE_W-1:0] store [DEPTH];
      logic [LANE_W-1:0] lane_q;

      always_ff @(posedge clk) begin
        if (wr_en && wr_be[g]) store[wr_addr] <= wr_data[g*LANE_W +: LANE_W];
        if (rd_en) lane_q <= store[rd_addr];
      end

      assign rd_q[g*LANE_W +: LANE_W] = lane_q;
    end
  endgenerate
endmodule

// File: rtl/zt_write_stage.sv
// Data-phase register, delayed write commit and read-after-write merge capture.
module zt_write_stage
  import zt_sram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clk_en,
  input  op_e                     issue_op,
  input  logic [ADDR_W-1:0]       issue_addr,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic [LANES-1:0]        byte_wr,
  output op_e                     ph_op,
  output logic                    commit_we,
  output logic [ADDR_W-1:0]       commit_addr,
  output logic                    fwd_hit,
  output logic [LANES*LANE_W-1:0] fwd_data,
  output logic [LANES-1:0]        fwd_be
);
  logic [ADDR_W-1:0] ph_addr;

  assign commit_we   = clk_en && !rst && (ph_op == OP_WRITE);
  assign commit_addr = ph_addr;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_op   <= OP_IDLE;
      ph_addr <= '0;
      fwd_hit <= 1'b0;
    end else if (clk_en) begin
      ph_op   <= issue_op;
      ph_addr <= issue_addr;
      fwd_hit <= (ph_op == OP_WRITE) && (issue_op == OP_READ) &&
                 (issue_addr == ph_addr);
    end
  end

  always_ff @(posedge clk) begin
    if (clk_en) begin
      fwd_data <= wdata;
      fwd_be   <= byte_wr;
    end
  end
endmodule

// File: rtl/zt_sram.sv
// Top level: command sequencer, delayed-write stage, lane array, read merge.
module zt_sram
  import zt_sram_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int LANES   = 4,
  parameter int LANE_W  = 9,
  parameter int BURST_W = 2,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clk_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              sel_a_n,
  input  logic              sel_b,
  input  logic              sel_c_n,
  input  logic              burst_adv,
  input  logic              order_ilv,
  input  logic              sleep,
  input  logic              out_en,
  input  logic [LANES-1:0]  byte_wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rdata_drive
);
  op_e               issue_op;
  logic [ADDR_W-1:0] issue_addr;
  op_e               ph_op;
  logic              commit_we;
  logic [ADDR_W-1:0] commit_addr;
  logic              fwd_hit;
  logic [DATA_W-1:0] fwd_data;
  logic [LANES-1:0]  fwd_be;
  logic [DATA_W-1:0] arr_q;

  zt_cmd_seq #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) u_cmd (
    .clk        (clk),
    .rst        (rst),
    .clk_en     (clk_en),
    .addr       (addr),
    .wr_en      (wr_en),
    .sel_a_n    (sel_a_n),
    .sel_b      (sel_b),
    .sel_c_n    (sel_c_n),
    .burst_adv  (burst_adv),
    .order_ilv  (order_ilv),
    .sleep      (sleep),
    .issue_op   (issue_op),
    .issue_addr (issue_addr)
  );

  zt_write_stage #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_wstage (
    .clk         (clk),
    .rst         (rst),
    .clk_en      (clk_en),
    .issue_op    (issue_op),
    .issue_addr  (issue_addr),
    .wdata       (wdata),
    .byte_wr     (byte_wr),
    .ph_op       (ph_op),
    .commit_we   (commit_we),
    .commit_addr (commit_addr),
    .fwd_hit     (fwd_hit),
    .fwd_data    (fwd_data),
    .fwd_be      (fwd_be)
  );

  zt_sram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk     (clk),
    .rd_en   (clk_en && (issue_op == OP_READ)),
    .rd_addr (issue_addr),
    .wr_en   (commit_we),
    .wr_addr (commit_addr),
    .wr_be   (byte_wr),
    .wr_data (wdata),
    .rd_q    (arr_q)
  );

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_merge
      assign rdata[g*LANE_W +: LANE_W] = (fwd_hit && fwd_be[g]) ?
                                         fwd_data[g*LANE_W +: LANE_W] :
                                         arr_q[g*LANE_W +: LANE_W];
    end
  endgenerate

  assign rdata_drive = out_en && (ph_op == OP_READ);
endmodule

// File: rtl/zt_sram_checks.sv
module zt_sram_checks
  import zt_sram_pkg::*;
#(
  parameter int DATA_W = 36
) (
  input logic              clk,
  input logic              rst,
  input logic              clk_en,
  input logic              burst_adv,
  input logic              sleep,
  input logic              sel_a_n,
  input logic              sel_b,
  input logic              sel_c_n,
  input logic              out_en,
  input logic              rdata_drive,
  input logic [DATA_W-1:0] rdata,
  input logic [1:0]        issue_op,
  input logic [1:0]        ph_op
);
  a_r1_drive_off_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !rdata_drive);

  a_r7_deselect_idle: assert property (@(posedge clk) disable iff (rst)
    (!burst_adv && (sel_a_n || !sel_b || sel_c_n)) |-> issue_op == OP_IDLE);

  a_r8_stall_holds: assert property (@(posedge clk) disable iff (rst)
    !clk_en |=> ($stable(rdata) && $stable(ph_op)));

  a_r9_oe_gates_drive: assert property (@(posedge clk) disable iff (rst)
    !out_en |-> !rdata_drive);

  a_r10_write_phase_quiet: assert property (@(posedge clk) disable iff (rst)
    (clk_en && issue_op == OP_WRITE) |=> !rdata_drive);

  a_r13_sleep_idle: assert property (@(posedge clk) disable iff (rst)
    sleep |-> issue_op == OP_IDLE);
endmodule

bind zt_sram zt_sram_checks #(.DATA_W(DATA_W)) u_checks (
  .clk         (clk),
  .rst         (rst),
  .clk_en      (clk_en),
  .burst_adv   (burst_adv),
  .sleep       (sleep),
  .sel_a_n     (sel_a_n),
  .sel_b       (sel_b),
  .sel_c_n     (sel_c_n),
  .out_en      (out_en),
  .rdata_drive (rdata_drive),
  .rdata       (rdata),
  .issue_op    (issue_op),
  .ph_op       (ph_op)
);

// File: tb/zt_sram_test.sv
module zt_sram_test;
  localparam int AW = 8;
  localparam int LN = 4;
  localparam int LW = 9;
  localparam int DW = LN * LW;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst, clk_en, wr_en, sel_a_n, sel_b, sel_c_n;
  logic burst_adv, order_ilv, sleep, out_en;
  logic [AW-1:0] addr;
  logic [LN-1:0] byte_wr;
  logic [DW-1:0] wdata, rdata;
  logic rdata_drive;

  zt_sram uut (
    .clk(clk), .rst(rst), .clk_en(clk_en), .addr(addr), .wr_en(wr_en),
    .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
    .burst_adv(burst_adv), .order_ilv(order_ilv), .sleep(sleep),
    .out_en(out_en), .byte_wr(byte_wr), .wdata(wdata),
    .rdata(rdata), .rdata_drive(rdata_drive)
  );

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;
  string tag = "R1";

  // reference model state: 0 idle, 1 read, 2 write
  int m_ph = 0, m_paddr = 0, m_last = 0, m_base = 0, m_cnt = 0;
  logic [DW-1:0] m_mem [int];
  logic [LN-1:0] m_known [int];
  logic [DW-1:0] m_q = '0;
  logic [LN-1:0] m_qk = '0;

  function automatic logic [DW-1:0] pat(int a, int k);
    return DW'(64'(a) * 64'h1F3D5 + 64'(k) * 64'h2C9 + 64'h9A5C3);
  endfunction

  task automatic chk_bit(logic act, logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: drive got %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic chk_lane(int ln, logic [LW-1:0] act, logic [LW-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: lane %0d got %h expected %h at %0t", tag, ln, act, exp, $time);
    end
  endtask

  task automatic model_edge();
    int op;
    int a;
    logic [DW-1:0] w;
    logic [LN-1:0] k;
    if (rst) begin
      m_ph = 0; m_last = 0; m_cnt = 0; m_base = 0;
      return;
    end
    if (!clk_en) return;
    if (m_ph == 2) begin
      w = m_mem.exists(m_paddr) ? m_mem[m_paddr] : '0;
      k = m_known.exists(m_paddr) ? m_known[m_paddr] : '0;
      for (int i = 0; i < LN; i++)
        if (byte_wr[i]) begin
          w[i*LW +: LW] = wdata[i*LW +: LW];
          k[i] = 1'b1;
        end
      m_mem[m_paddr] = w;
      m_known[m_paddr] = k;
    end
    a = int'(addr);
    if (burst_adv) begin
      m_cnt = (m_cnt + 1) % 4;
      a = (m_base & ~3) | (order_ilv ? ((m_base & 3) ^ m_cnt) : (((m_base & 3) + m_cnt) % 4));
    end else begin
      m_base = int'(addr);
      m_cnt = 0;
    end
    if (sleep) op = 0;
    else if (burst_adv) op = m_last;
    else if (!sel_a_n && sel_b && !sel_c_n) op = wr_en ? 2 : 1;
    else op = 0;
    if (op == 1) begin
      m_q  = m_mem.exists(a) ? m_mem[a] : '0;
      m_qk = m_known.exists(a) ? m_known[a] : '0;
    end
    m_last = op;
    m_ph = op;
    m_paddr = a;
  endtask

  task automatic compare();
    chk_bit(rdata_drive, out_en && (m_ph == 1));
    if (m_ph == 1)
      for (int i = 0; i < LN; i++)
        if (m_qk[i]) chk_lane(i, rdata[i*LW +: LW], m_q[i*LW +: LW]);
  endtask

  task automatic tick();
    model_edge();
    @(posedge clk);
    #1;
    compare();
    @(negedge clk);
  endtask

  task automatic cyc(bit sel, bit we, int a, bit adv, logic [DW-1:0] d, logic [LN-1:0] be);
    sel_a_n = !sel; sel_b = sel; sel_c_n = !sel;
    wr_en = we; addr = AW'(a); burst_adv = adv; wdata = d; byte_wr = be;
    tick();
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    end
  endtask

  initial begin
    #2000000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    rst = 1; clk_en = 1; wr_en = 0; sel_a_n = 1; sel_b = 0; sel_c_n = 1;
    burst_adv = 0; order_ilv = 0; sleep = 0; out_en = 1;
    addr = '0; byte_wr = '0; wdata = '0;
    @(negedge clk);
    // R1: reset state
    tag = "R1";
    tick(); tick();
    rst = 0;
    cyc(0, 0, 0, 0, '0, '0);

    // R3: back-to-back full writes, data one edge behind the address
    tag = "R3";
    for (int i = 0; i < 5; i++)
      cyc(i < 4, 1, i, 0, pat(i - 1, 0), (i > 0) ? 4'hF : 4'h0);
    // R2: flow-through reads
    tag = "R2";
    for (int i = 0; i < 4; i++) cyc(1, 0, i, 0, '0, '0);
    cyc(0, 0, 0, 0, '0, '0);

    // R4: partial byte mask
    tag = "R4";
    cyc(1, 1, 0, 0, '0, '0);
    cyc(0, 0, 0, 0, pat(0, 7), 4'b0101);
    cyc(1, 0, 0, 0, '0, '0);
    cyc(0, 0, 0, 0, '0, '0);

    // R6: read hitting the write committing at the same edge
    tag = "R6";
    cyc(1, 1, 1, 0, '0, '0);
    cyc(1, 0, 1, 0, pat(1, 9), 4'b1010);
    cyc(1, 0, 1, 0, '0, '0);
    cyc(1, 1, 2, 0, '0, '0);
    cyc(1, 0, 2, 0, pat(2, 9), 4'b0110);
    cyc(0, 0, 0, 0, '0, '0);

    // R5: alternating write / read every clock
    tag = "R5";
    for (int i = 0; i < 12; i++) begin
      if (i % 2 == 0) cyc(1, 1, 20 + i, 0, '0, '0);
      else            cyc(1, 0, 20 + i - 1, 0, pat(20 + i - 1, 3), 4'hF);
    end
    for (int i = 0; i < 12; i += 2) cyc(1, 0, 20 + i, 0, '0, '0);
    cyc(0, 0, 0, 0, '0, '0);

    // R7: each chip select alone blocks a write and a read
    tag = "R7";
    for (int v = 0; v < 3; v++) begin
      sel_a_n = (v == 0); sel_b = (v != 1); sel_c_n = (v == 2);
      wr_en = 1; addr = AW'(3); burst_adv = 0; tick();
      cyc(0, 0, 0, 0, pat(99, v), 4'hF);
      sel_a_n = (v == 0); sel_b = (v != 1); sel_c_n = (v == 2);
      wr_en = 0; addr = AW'(3); tick();
      cyc(1, 0, 3, 0, '0, '0);
    end
    cyc(0, 0, 0, 0, '0, '0);

    // R8: stall holds read output and defers a pending write
    tag = "R8";
    cyc(1, 0, 3, 0, '0, '0);
    clk_en = 0;
    cyc(1, 0, 0, 0, '0, '0);
    cyc(1, 1, 5, 0, pat(5, 5), 4'hF);
    clk_en = 1;
    cyc(1, 1, 6, 0, '0, '0);
    clk_en = 0;
    cyc(1, 1, 7, 0, pat(66, 1), 4'hF);
    cyc(0, 0, 0, 0, pat(66, 2), 4'hF);
    clk_en = 1;
    cyc(1, 0, 6, 0, pat(6, 4), 4'hF);
    cyc(1, 0, 7, 0, '0, '0);
    cyc(0, 0, 0, 0, '0, '0);

    // R9: asynchronous output enable
    tag = "R9";
    cyc(1, 0, 6, 0, '0, '0);
    out_en = 0; #1; chk_bit(rdata_drive, 1'b0);
    out_en = 1; #1; chk_bit(rdata_drive, 1'b1);
    cyc(0, 0, 0, 0, '0, '0);

    // R10: write data phases keep the bus released with out_en high
    tag = "R10";
    cyc(1, 0, 6, 0, '0, '0);
    cyc(1, 1, 8, 0, '0, '0);
    cyc(1, 1, 9, 0, pat(8, 1), 4'hF);
    cyc(1, 0, 8, 0, pat(9, 1), 4'hF);
    cyc(0, 0, 0, 0, '0, '0);

    // R11: linear burst write then read back
    tag = "R11";
    order_ilv = 0;
    cyc(1, 1, 8'h42, 0, '0, '0);
    for (int n = 1; n < 4; n++) cyc(0, 0, 0, 1, pat(8'h40, n), 4'hF);
    cyc(0, 0, 0, 0, pat(8'h40, 4), 4'hF);
    for (int a = 8'h40; a < 8'h44; a++) cyc(1, 0, a, 0, '0, '0);
    cyc(1, 0, 8'h43, 0, '0, '0);
    for (int n = 1; n < 4; n++) cyc(0, 0, 0, 1, '0, '0);
    cyc(0, 0, 0, 0, '0, '0);

    // R12: interleaved burst write then read back
    tag = "R12";
    order_ilv = 1;
    cyc(1, 1, 8'h61, 0, '0, '0);
    for (int n = 1; n < 4; n++) cyc(0, 0, 0, 1, pat(8'h60, n), 4'hF);
    cyc(0, 0, 0, 0, pat(8'h60, 4), 4'hF);
    for (int a = 8'h60; a < 8'h64; a++) cyc(1, 0, a, 0, '0, '0);
    cyc(1, 0, 8'h62, 0, '0, '0);
    for (int n = 1; n < 4; n++) cyc(0, 0, 0, 1, '0, '0);
    order_ilv = 0;
    cyc(0, 0, 0, 0, '0, '0);

    // R13: sleep idles commands, pending write still lands
    tag = "R13";
    cyc(1, 1, 5, 0, '0, '0);
    sleep = 1;
    cyc(1, 0, 5, 0, pat(5, 13), 4'hF);
    cyc(1, 1, 5, 0, pat(77, 0), 4'hF);
    cyc(0, 0, 0, 1, pat(77, 1), 4'hF);
    sleep = 0;
    cyc(0, 0, 0, 1, '0, '0);
    cyc(1, 0, 5, 0, '0, '0);
    cyc(0, 0, 0, 0, '0, '0);

    summary();
    $finish;
  end
endmodule